// File: doc/BRIEF.md
# Multi-Level Interrupt Request Arbiter

This block collects interrupt requests from up to `NUM_LEVELS * 32` sources, arranged as levels of 32 request bits. Each source has its own request flag and enable flag. A single pending line tells the processor when at least one source is both requesting and enabled. When the processor acknowledges, the arbiter chooses one winner and clears its request flag. It then translates the winner's position into a device number through a small mapping RAM, which is written at configuration time.

Devices raise and drop their requests through indexed set and clear strobes. Enables are changed by an indexed control strobe that carries a 2-bit command. The command logic also returns an "armed" status. The winner is the source with the lowest flat index, where the flat index is `level * 32 + bit`. So level 0 is served before level 1, and within a level bit 0 is served before bit 31.

Top module: `irq_arbiter`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), every request flag is clear, every enable flag is set, `irq_pending` is 0 and `ack_dev` is 0. The mapping RAM is not reset.
- R2: `irq_pending` is 1 exactly when some source has both its request flag and its enable flag set. It reflects the flags as they stand after each clock edge.
- R3: On `ack_stb`, the winner is the enabled, requesting source with the lowest flat index `level*32+bit`.
- R4: On `ack_stb` with a winner, the winner's request flag clears at that edge. From the next cycle, `ack_dev` holds mapping RAM entry [flat index]. `ack_dev` keeps that value until the next acknowledge or reset.
- R5: On `ack_stb` with no enabled request pending, `ack_dev` becomes 0 and no flag changes. A source whose enable is clear is never granted, even when its request flag is set.
- R6: A control strobe with command 2'b01 sets the addressed enable flag. Command 2'b10 clears it. Both commands drive `ctl_armed_o` to 1 in the same cycle.
- R7: Command 2'b11 clears both the addressed enable flag and the addressed request flag, and drives `ctl_armed_o` to 0.
- R8: Command 2'b00, or `ctl_stb` low, changes no flag, and `ctl_armed_o` equals `ctl_armed_i`.
- R9: `req_set_stb` sets the addressed request flag and `req_clr_stb` clears it. When a set and any clear (strobe, acknowledge or disarm) hit the same bit in the same cycle, the set wins.
- R10: When `map_we` is high at a clock edge, `map_wdata` is written to mapping entry `map_addr`. Later acknowledges of that source return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set_stb | input | 1 | Set the request flag of source `req_set_idx` |
| req_set_idx | input | IDX_W | Flat source index for set |
| req_clr_stb | input | 1 | Clear the request flag of source `req_clr_idx` |
| req_clr_idx | input | IDX_W | Flat source index for clear |
| ctl_stb | input | 1 | Apply `ctl_cmd` to source `ctl_idx` |
| ctl_idx | input | IDX_W | Flat source index for the command |
| ctl_cmd | input | 2 | 00 none, 01 enable, 10 disable, 11 disarm |
| ctl_armed_i | input | 1 | Previous armed status, passed through when no command applies |
| ctl_armed_o | output | 1 | Armed status resulting from the command (combinational) |
| map_we | input | 1 | Mapping RAM write enable |
| map_addr | input | IDX_W | Mapping RAM write address |
| map_wdata | input | DEV_W | Device number to store |
| ack_stb | input | 1 | Single-cycle acknowledge from the processor |
| ack_dev | output | DEV_W | Granted device number, registered |
| irq_pending | output | 1 | Some enabled request is pending |

## Verification
The bench targets the seams where priority could be ordered wrongly. These are bit 31 of level 0 against bit 0 of level 1, and two requests on level 3; a design that ranked by level alone or scanned from the top bit would return the wrong device. It sets and acknowledges the same bit in the same cycle: a design that let the clear win would drop `irq_pending`. It also leaves a request raised while its enable is clear: a design that granted it, or forgot it, would return a device too early or never. A disarm is followed by a re-enable, so a design that cleared only the enable would raise `irq_pending` again. A command-free control strobe and an idle strobe must pass the armed input through, and a rewrite of a mapping entry must show up in the next grant.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int WORD_BITS = 32;

  typedef enum logic [1:0] {
    CTL_NONE    = 2'b00,
    CTL_ENABLE  = 2'b01,
    CTL_DISABLE = 2'b10,
    CTL_DISARM  = 2'b11
  } ctl_cmd_e;

  // Armed status that results from a control command.
  function automatic logic armed_after(input logic stb, input ctl_cmd_e cmd,
                                       input logic prev);
    if (!stb) return prev;
    case (cmd)
      CTL_ENABLE, CTL_DISABLE: return 1'b1;
      CTL_DISARM:              return 1'b0;
      default:                 return prev;
    endcase
  endfunction

endpackage

// File: rtl/irq_level_bank.sv
module irq_level_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_set_mask,
  input  logic [W-1:0] req_clr_mask,
  input  logic [W-1:0] enb_set_mask,
  input  logic [W-1:0] enb_clr_mask,
  output logic [W-1:0] req_q,
  output logic [W-1:0] enb_q
);

  logic [W-1:0] req_d;
  logic [W-1:0] enb_d;

  // Clears are applied first, so a set on the same bit wins.
  assign req_d = (req_q & ~req_clr_mask) | req_set_mask;
  assign enb_d = (enb_q & ~enb_clr_mask) | enb_set_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      enb_q <= '1;
    end else begin
      req_q <= req_d;
      enb_q <= enb_d;
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = 128,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  assign found = |pend_vec;

  // Scan downward so the lowest set index is the last assignment.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_vec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_dev_map.sv
module irq_dev_map #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int DEV_W      = 8,
  localparam int NSRC      = NUM_LEVELS * WORD_BITS,
  localparam int IDX_W     = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_set_stb,
  input  logic [IDX_W-1:0] req_set_idx,
  input  logic             req_clr_stb,
  input  logic [IDX_W-1:0] req_clr_idx,
  input  logic             ctl_stb,
  input  logic [IDX_W-1:0] ctl_idx,
  input  logic [1:0]       ctl_cmd,
  input  logic             ctl_armed_i,
  output logic             ctl_armed_o,
  input  logic             map_we,
  input  logic [IDX_W-1:0] map_addr,
  input  logic [DEV_W-1:0] map_wdata,
  input  logic             ack_stb,
  output logic [DEV_W-1:0] ack_dev,
  output logic             irq_pending
);

  logic [NSRC-1:0]  req_flat, enb_flat, pend_vec;
  logic [NSRC-1:0]  set_oh, clr_oh, ctl_oh, grant_oh;
  logic [NSRC-1:0]  req_clr_all, enb_set_all, enb_clr_all;
  logic             grant_found, grant_fire;
  logic [IDX_W-1:0] grant_idx;
  logic [DEV_W-1:0] map_rdata;
  ctl_cmd_e         cmd_e;
  logic             cmd_en, cmd_dis, cmd_dsa;

  // Index decode
  assign set_oh   = req_set_stb ? (NSRC'(1) << req_set_idx) : '0;
  assign clr_oh   = req_clr_stb ? (NSRC'(1) << req_clr_idx) : '0;
  assign ctl_oh   = ctl_stb     ? (NSRC'(1) << ctl_idx)     : '0;
  assign grant_oh = grant_fire  ? (NSRC'(1) << grant_idx)   : '0;

  assign cmd_e   = ctl_cmd_e'(ctl_cmd);
  assign cmd_en  = ctl_stb && (cmd_e == CTL_ENABLE);
  assign cmd_dis = ctl_stb && (cmd_e == CTL_DISABLE);
  assign cmd_dsa = ctl_stb && (cmd_e == CTL_DISARM);

  assign req_clr_all = clr_oh | grant_oh | (cmd_dsa ? ctl_oh : '0);
  assign enb_set_all = cmd_en ? ctl_oh : '0;
  assign enb_clr_all = (cmd_dis || cmd_dsa) ? ctl_oh : '0;

  assign ctl_armed_o = armed_after(ctl_stb, cmd_e, ctl_armed_i);

  // One bank per level
  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
    irq_level_bank #(.W(WORD_BITS)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_set_mask (set_oh[lv*WORD_BITS +: WORD_BITS]),
      .req_clr_mask (req_clr_all[lv*WORD_BITS +: WORD_BITS]),
      .enb_set_mask (enb_set_all[lv*WORD_BITS +: WORD_BITS]),
      .enb_clr_mask (enb_clr_all[lv*WORD_BITS +: WORD_BITS]),
      .req_q        (req_flat[lv*WORD_BITS +: WORD_BITS]),
      .enb_q        (enb_flat[lv*WORD_BITS +: WORD_BITS])
    );
  end

  assign pend_vec    = req_flat & enb_flat;
  assign irq_pending = |pend_vec;

  irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
    .pend_vec (pend_vec),
    .found    (grant_found),
    .idx      (grant_idx)
  );

  assign grant_fire = ack_stb && grant_found;

  irq_dev_map #(.DEPTH(NSRC), .AW(IDX_W), .DW(DEV_W)) u_map (
    .clk   (clk),
    .we    (map_we),
    .waddr (map_addr),
    .wdata (map_wdata),
    .raddr (grant_idx),
    .rdata (map_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ack_dev <= '0;
    else if (ack_stb) ack_dev <= grant_found ? map_rdata : '0;
  end

  // Assertions
  AST_GRANT_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    grant_found |-> pend_vec[grant_idx]);  // R3
  AST_GRANT_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    grant_found |-> ((pend_vec & ((NSRC'(1) << grant_idx) - NSRC'(1))) == '0));  // R3
  AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_fire && !(req_set_stb && req_set_idx == grant_idx))
      |=> !req_flat[$past(grant_idx)]);  // R4
  AST_IDLE_ACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && !irq_pending) |=> (ack_dev == '0));  // R5
  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en |=> enb_flat[$past(ctl_idx)]);  // R6
  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_dsa && !(req_set_stb && req_set_idx == ctl_idx))
      |=> (!enb_flat[$past(ctl_idx)] && !req_flat[$past(ctl_idx)]));  // R7
  AST_NO_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_stb || cmd_e == CTL_NONE) |=> $stable(enb_flat));  // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_set_stb |=> req_flat[$past(req_set_idx)]);  // R9

endmodule

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;

  localparam int  NSRC  = 128;
  localparam int  IW    = 7;
  localparam real HALF  = 2.5;

  localparam logic [2:0] OP_SET = 3'd0, OP_CLR = 3'd1, OP_CTL = 3'd2,
                         OP_ACK = 3'd3, OP_SETACK = 3'd4;

  typedef struct packed {
    logic [2:0] op;
    logic [6:0] idx;
    logic [1:0] cmd;
    logic       armed_in;
    logic [7:0] exp;   // ACK: winner index or FF; CTL: bit0 = armed
    logic       pend;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'hFF, 1'b0},  // R5 idle ack
    '{OP_SET, 7'd40,  2'd0, 1'b0, 8'h00, 1'b1},  // R9 R2
    '{OP_SET, 7'd5,   2'd0, 1'b0, 8'h00, 1'b1},
    '{OP_SET, 7'd70,  2'd0, 1'b0, 8'h00, 1'b1},
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'd5,  1'b1},  // R3 R4
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'd40, 1'b1},
    '{OP_CTL, 7'd70,  2'd2, 1'b0, 8'h01, 1'b0},  // R6 disable
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'hFF, 1'b0},  // R5 disabled not granted
    '{OP_CTL, 7'd70,  2'd1, 1'b0, 8'h01, 1'b1},  // R6 enable
    '{OP_CTL, 7'd70,  2'd3, 1'b1, 8'h00, 1'b0},  // R7 disarm
    '{OP_CTL, 7'd70,  2'd1, 1'b0, 8'h01, 1'b0},  // R7 request gone
    '{OP_CTL, 7'd3,   2'd0, 1'b1, 8'h01, 1'b0},  // R8
    '{OP_CTL, 7'd3,   2'd0, 1'b0, 8'h00, 1'b0},  // R8
    '{OP_SET, 7'd127, 2'd0, 1'b0, 8'h00, 1'b1},
    '{OP_SET, 7'd96,  2'd0, 1'b0, 8'h00, 1'b1},
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'd96, 1'b1},  // R3 level 3
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'd127,1'b0},
    '{OP_SET, 7'd33,  2'd0, 1'b0, 8'h00, 1'b1},
    '{OP_CLR, 7'd33,  2'd0, 1'b0, 8'h00, 1'b0},  // R9 clear
    '{OP_SET, 7'd10,  2'd0, 1'b0, 8'h00, 1'b1},
    '{OP_SETACK,7'd10,2'd0, 1'b0, 8'd10, 1'b1},  // R9 set wins over ack
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'd10, 1'b0},
    '{OP_SET, 7'd32,  2'd0, 1'b0, 8'h00, 1'b1},
    '{OP_SET, 7'd31,  2'd0, 1'b0, 8'h00, 1'b1},
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'd31, 1'b1},  // R3 level seam
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'd32, 1'b0},
    '{OP_CTL, 7'd31,  2'd2, 1'b0, 8'h01, 1'b0},
    '{OP_SET, 7'd31,  2'd0, 1'b0, 8'h00, 1'b0},  // R2 disabled request
    '{OP_SET, 7'd64,  2'd0, 1'b0, 8'h00, 1'b1},
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'd64, 1'b0},  // R5 skip disabled
    '{OP_CTL, 7'd31,  2'd1, 1'b0, 8'h01, 1'b1},
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'd31, 1'b0},
    '{OP_CTL, 7'd50,  2'd3, 1'b1, 8'h00, 1'b0},  // R7 disarm idle
    '{OP_SET, 7'd50,  2'd0, 1'b0, 8'h00, 1'b0},
    '{OP_CTL, 7'd50,  2'd1, 1'b0, 8'h01, 1'b1},
    '{OP_ACK, 7'd0,   2'd0, 1'b0, 8'd50, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_set_stb = 0, req_clr_stb = 0, ctl_stb = 0, map_we = 0, ack_stb = 0;
  logic [IW-1:0] req_set_idx = '0, req_clr_idx = '0, ctl_idx = '0, map_addr = '0;
  logic [1:0]    ctl_cmd = '0;
  logic          ctl_armed_i = 1'b0;
  logic          ctl_armed_o;
  logic [7:0]    map_wdata = '0;
  logic [7:0]    ack_dev;
  logic          irq_pending;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(HALF) clk = ~clk;

  irq_arbiter uut (
    .clk(clk), .rst_n(rst_n),
    .req_set_stb(req_set_stb), .req_set_idx(req_set_idx),
    .req_clr_stb(req_clr_stb), .req_clr_idx(req_clr_idx),
    .ctl_stb(ctl_stb), .ctl_idx(ctl_idx), .ctl_cmd(ctl_cmd),
    .ctl_armed_i(ctl_armed_i), .ctl_armed_o(ctl_armed_o),
    .map_we(map_we), .map_addr(map_addr), .map_wdata(map_wdata),
    .ack_stb(ack_stb), .ack_dev(ack_dev), .irq_pending(irq_pending)
  );

  function automatic logic [7:0] devof(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    req_set_stb = 0; req_clr_stb = 0; ctl_stb = 0; ack_stb = 0; map_we = 0;
    ctl_cmd = '0; ctl_armed_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pending", irq_pending, 0);
    check("R1 ack_dev", ack_dev, 0);
    // R10 load mapping RAM while in reset
    for (int i = 0; i < NSRC; i++) begin
      map_we = 1; map_addr = IW'(i); map_wdata = devof(i);
      @(negedge clk);
    end
    map_we = 0;
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VEC[v];
      idle();
      case (t.op)
        OP_SET:    begin req_set_stb = 1; req_set_idx = t.idx; end
        OP_CLR:    begin req_clr_stb = 1; req_clr_idx = t.idx; end
        OP_CTL:    begin ctl_stb = 1; ctl_idx = t.idx; ctl_cmd = t.cmd;
                         ctl_armed_i = t.armed_in; end
        OP_ACK:    ack_stb = 1;
        OP_SETACK: begin ack_stb = 1; req_set_stb = 1; req_set_idx = t.idx; end
        default: ;
      endcase
      #1;
      if (t.op == OP_CTL) check("R6 R7 R8 armed", ctl_armed_o, t.exp[0]);
      @(negedge clk);
      idle();
      if (t.op == OP_ACK || t.op == OP_SETACK)
        check("R3 R4 R5 ack_dev", ack_dev,
              (t.exp == 8'hFF) ? 0 : devof(int'(t.exp)));
      check("R2 pending", irq_pending, t.pend);
    end

    // R8: strobe low passes armed through and changes nothing
    req_set_stb = 1; req_set_idx = 7'd12;
    @(negedge clk);
    idle();
    ctl_stb = 0; ctl_idx = 7'd12; ctl_cmd = 2'b11; ctl_armed_i = 1;
    #1;
    check("R8 armed idle", ctl_armed_o, 1);
    @(negedge clk);
    idle();
    check("R8 no change", irq_pending, 1);
    ack_stb = 1;
    @(negedge clk);
    idle();
    check("R8 ack after idle", ack_dev, devof(12));

    // R10: rewrite one entry
    map_we = 1; map_addr = 7'd2; map_wdata = 8'hA5;
    req_set_stb = 1; req_set_idx = 7'd2;
    @(negedge clk);
    idle();
    ack_stb = 1;
    @(negedge clk);
    idle();
    check("R10 rewritten entry", ack_dev, 8'hA5);

    // R1: reset mid-operation, enables come back set
    ctl_stb = 1; ctl_idx = 7'd9; ctl_cmd = 2'b10;
    @(negedge clk);
    idle();
    req_set_stb = 1; req_set_idx = 7'd9;
    @(negedge clk);
    idle();
    check("R1 disabled pre-reset", irq_pending, 0);
    rst_n = 0;
    @(negedge clk);
    check("R1 pending after reset", irq_pending, 0);
    check("R1 ack_dev after reset", ack_dev, 0);
    rst_n = 1;
    req_set_stb = 1; req_set_idx = 7'd9;
    @(negedge clk);
    idle();
    check("R1 enable restored", irq_pending, 1);
    ack_stb = 1;
    @(negedge clk);
    idle();
    check("R1 map kept", ack_dev, devof(9));
    check("R4 cleared", irq_pending, 0);

    finish_run();
  end

endmodule